// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block gathers the level-sensitive INTA..INTD lines of a set of device slots and steers them onto interrupt controller pins. Each slot pin is first mapped onto one of eight shared interrupt lines, called links 0..7 here. Every link then reaches the controllers by two paths that are active at the same time. On the legacy path, a per-link route register picks one of 16 legacy controller pins, and pins shared by several links take the OR of their levels. On the advanced path, link n always drives advanced pin 16+n, whatever its route register holds.

A level-sensitive system control interrupt (SCI) input is ORed onto one pin chosen by software. That pin can be legacy pin 9, 10 or 11, or advanced pin 20 or 21. Software reaches all routing state through a byte-wide write port and a combinational read port. One slot is a bridge whose mapping is fixed and cannot be programmed. All controller outputs are registered.

Top module: `pirq_router`

## Requirements
- R1: Link route registers are at addresses 0x00..0x07, one per link 0..7. Bits [4:0] hold the legacy pin number and bit 7 is the disable bit. Bits 6:5 read as zero, and each register resets to 0x80.
- R2: Legacy pin p (0..15) is high when some link is high whose route register has bit 7 clear and bits [4:0] equal to p. Several links on one pin are ORed.
- R3: Advanced output bit n (pin 16+n) follows the level of link n alone and ignores that link's route register.
- R4: The SCI select register is at address 0x08, bits [2:0], and resets to 0. Code 0 selects legacy pin 9, code 1 pin 10, code 2 pin 11, code 4 advanced bit 4 (pin 20) and code 5 advanced bit 5 (pin 21). The SCI level is ORed onto the selected pin.
- R5: A write of code 3, 6 or 7 to the SCI select register is ignored: the readback and the SCI pin stay as they were.
- R6: If the SCI select changes while SCI is high, the old pin falls and the new pin rises in the same output update.
- R7: Slot mapping bytes sit at 0x10+2s and 0x11+2s for slot s. The low byte holds INTA in bits [2:0] and INTB in bits [6:4]. The high byte holds INTC in bits [2:0] and INTD in bits [6:4]. Bits 3 and 7 read as zero. A link is high when any slot pin mapped to it is high. Input bit 4s+i carries pin i of slot s, with i running 0..3 for INTA..INTD.
- R8: After reset, pin i of slot s maps to link ((s+i) mod 4)+4, so links 0..3 stay unused.
- R9: The fixed slot (parameter FIXED_SLOT, default 6) reads as zero and ignores writes. Its pin i always drives link 4+i.
- R10: Output route_ok[n] is high exactly when route register n has bit 7 clear and bits [4:0] below 16. It follows the register without an output stage. An enabled route with a pin number of 16 or more drives no legacy pin.
- R11: While reset is asserted all legacy and advanced outputs are low. Afterwards each output reflects the inputs and registers as sampled at the previous clock edge.
- R12: A read of any address outside the route, SCI select and slot mapping ranges returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 8 | Read byte, combinational |
| intx_in | input | 4*NSLOT | Slot interrupt pin levels, bit 4s+i |
| sci_in | input | 1 | SCI level |
| pic_irq | output | 16 | Legacy controller pins 0..15 |
| apic_irq | output | 8 | Advanced controller pins 16..23 |
| route_ok | output | 8 | Per-link legacy route valid |

## Verification
The SCI and a link can land on the same advanced pin: SCI code 4 shares pin 20 with link 4, and code 5 shares pin 21 with link 5. A link and the SCI can likewise share a legacy pin 9..11 when the link's route selects it. The random phase covers these cases by drawing SCI codes, route fields in 0..31 and sparse slot levels together. Each output is judged against the OR that the bench model computes for both paths. A directed step moves the SCI select while SCI is high and checks that the old pin and the new pin swap in the same output update, not one update apart.

// File: rtl/pirq_router_pkg.sv
// Shared constants and SCI select decoding for the interrupt line router.
// Assumes eight links, four pins per slot and 16 legacy controller pins.
package pirq_router_pkg;
    localparam int NLINK     = 8;
    localparam int NPIN      = 4;
    localparam int NLEGACY   = 16;
    localparam int NADV      = 8;
    localparam int ROUTE_DIS = 7;
    localparam logic [7:0] ROUTE_MASK  = 8'h9F;
    localparam logic [7:0] ROUTE_RESET = 8'h80;
    localparam int SCI_ADDR  = 8;
    localparam int MAP_BASE  = 16;

    // True for select codes that name a pin
    function automatic logic sci_code_ok(input logic [2:0] code);
        return (code == 3'd0) || (code == 3'd1) || (code == 3'd2) ||
               (code == 3'd4) || (code == 3'd5);
    endfunction

    // Controller pin number (0..23) for a valid select code
    function automatic logic [4:0] sci_pin(input logic [2:0] code);
        case (code)
            3'd1:    return 5'd10;
            3'd2:    return 5'd11;
            3'd4:    return 5'd20;
            3'd5:    return 5'd21;
            default: return 5'd9;
        endcase
    endfunction
endpackage

// File: rtl/pirq_router_regs.sv
// Register file: link routes, SCI select and per-slot pin mappings, with a
// combinational read port. Assumes AW wide enough for MAP_BASE + 2*NSLOT.
module pirq_router_regs
    import pirq_router_pkg::*;
#(
    parameter int NSLOT      = 8,
    parameter int FIXED_SLOT = 6,
    parameter int AW         = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [AW-1:0]                        wr_addr,
    input  logic [7:0]                           wr_data,
    input  logic [AW-1:0]                        rd_addr,
    output logic [7:0]                           rd_data,
    output logic [NLINK-1:0][7:0]                route,
    output logic [2:0]                           sci_code,
    output logic [NSLOT-1:0][NPIN-1:0][2:0]      map_sel
);
    logic [NLINK-1:0][7:0] route_q;
    logic [2:0]            sci_q;

    // Link route registers: masked byte writes
    always_ff @(posedge clk) begin
        for (int n = 0; n < NLINK; n++) begin
            if (!rst_n)
                route_q[n] <= ROUTE_RESET;
            else if (wr_en && wr_addr == AW'(n))
                route_q[n] <= wr_data & ROUTE_MASK;
        end
    end

    // SCI select: only codes that name a pin are accepted
    always_ff @(posedge clk) begin
        if (!rst_n)
            sci_q <= 3'd0;
        else if (wr_en && wr_addr == AW'(SCI_ADDR) && sci_code_ok(wr_data[2:0]))
            sci_q <= wr_data[2:0];
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [AW-1:0] LO_ADDR = AW'(MAP_BASE + 2 * s);
        localparam logic [AW-1:0] HI_ADDR = AW'(MAP_BASE + 2 * s + 1);
        if (s == FIXED_SLOT) begin : g_fixed
            for (genvar i = 0; i < NPIN; i++) begin : g_pin
                assign map_sel[s][i] = 3'(4 + i);
            end
        end else begin : g_prog
            logic [NPIN-1:0][2:0] fld_q;
            // Programmable mapping fields, two per byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < NPIN; i++)
                        fld_q[i] <= 3'(((s + i) % 4) + 4);
                end else if (wr_en && wr_addr == LO_ADDR) begin
                    fld_q[0] <= wr_data[2:0];
                    fld_q[1] <= wr_data[6:4];
                end else if (wr_en && wr_addr == HI_ADDR) begin
                    fld_q[2] <= wr_data[2:0];
                    fld_q[3] <= wr_data[6:4];
                end
            end
            assign map_sel[s] = fld_q;
        end
    end

    // Read mux; unmapped addresses and the fixed slot return zero
    always_comb begin
        rd_data = 8'h00;
        for (int n = 0; n < NLINK; n++)
            if (rd_addr == AW'(n)) rd_data = route_q[n];
        if (rd_addr == AW'(SCI_ADDR)) rd_data = {5'b0, sci_q};
        for (int s = 0; s < NSLOT; s++) begin
            if (s != FIXED_SLOT) begin
                if (rd_addr == AW'(MAP_BASE + 2 * s))
                    rd_data = {1'b0, map_sel[s][1], 1'b0, map_sel[s][0]};
                if (rd_addr == AW'(MAP_BASE + 2 * s + 1))
                    rd_data = {1'b0, map_sel[s][3], 1'b0, map_sel[s][2]};
            end
        end
    end

    assign route    = route_q;
    assign sci_code = sci_q;
endmodule

// File: rtl/pirq_router_combine.sv
// Folds every slot pin onto the link its mapping field selects (wired OR).
// Purely combinational; assumes levels, not edges.
module pirq_router_combine
    import pirq_router_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic [NPIN*NSLOT-1:0]            intx_in,
    input  logic [NSLOT-1:0][NPIN-1:0][2:0]  map_sel,
    output logic [NLINK-1:0]                 link_lvl
);
    // OR each high slot pin into its selected link
    always_comb begin
        link_lvl = '0;
        for (int s = 0; s < NSLOT; s++)
            for (int i = 0; i < NPIN; i++)
                if (intx_in[NPIN * s + i]) link_lvl[map_sel[s][i]] = 1'b1;
    end
endmodule

// File: rtl/pirq_router_merge.sv
// Drives link levels onto the legacy pins through the route registers and
// onto the advanced pins one to one, merges the SCI, and registers outputs.
module pirq_router_merge
    import pirq_router_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLINK-1:0]      link_lvl,
    input  logic [NLINK-1:0][7:0] route,
    input  logic                  sci_in,
    input  logic [2:0]            sci_code,
    output logic [NLEGACY-1:0]    pic_irq,
    output logic [NADV-1:0]       apic_irq,
    output logic [NLINK-1:0]      route_ok
);
    logic [NLEGACY-1:0] pic_nxt;
    logic [NADV-1:0]    apic_nxt;
    logic [4:0]         sci_pin_num;

    // A route reaches a legacy pin only when enabled and below 16
    always_comb begin
        for (int n = 0; n < NLINK; n++)
            route_ok[n] = !route[n][ROUTE_DIS] && !route[n][4];
    end

    assign sci_pin_num = sci_pin(sci_code);

    // Next pin levels: link ORs plus the SCI on its selected pin
    always_comb begin
        pic_nxt  = '0;
        apic_nxt = link_lvl;
        for (int n = 0; n < NLINK; n++)
            if (route_ok[n] && link_lvl[n]) pic_nxt[route[n][3:0]] = 1'b1;
        if (sci_in) begin
            if (sci_pin_num[4]) apic_nxt[sci_pin_num[2:0]] = 1'b1;
            else                pic_nxt[sci_pin_num[3:0]]  = 1'b1;
        end
    end

    // Output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pic_irq  <= '0;
            apic_irq <= '0;
        end else begin
            pic_irq  <= pic_nxt;
            apic_irq <= apic_nxt;
        end
    end
endmodule

// File: rtl/pirq_router.sv
// Top of the interrupt line router: register file, slot-to-link fold and
// controller pin merge. Assumes synchronous active-low reset.
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int NSLOT      = 8,
    parameter int FIXED_SLOT = 6,
    parameter int AW         = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    input  logic [4*NSLOT-1:0]    intx_in,
    input  logic                  sci_in,
    output logic [15:0]           pic_irq,
    output logic [7:0]            apic_irq,
    output logic [7:0]            route_ok
);
    logic [NLINK-1:0][7:0]              route;
    logic [2:0]                         sci_code;
    logic [NSLOT-1:0][NPIN-1:0][2:0]    map_sel;
    logic [NLINK-1:0]                   link_lvl;

    pirq_router_regs #(.NSLOT(NSLOT), .FIXED_SLOT(FIXED_SLOT), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .route(route), .sci_code(sci_code), .map_sel(map_sel)
    );

    pirq_router_combine #(.NSLOT(NSLOT)) u_combine (
        .intx_in(intx_in), .map_sel(map_sel), .link_lvl(link_lvl)
    );

    pirq_router_merge u_merge (
        .clk(clk), .rst_n(rst_n), .link_lvl(link_lvl), .route(route),
        .sci_in(sci_in), .sci_code(sci_code), .pic_irq(pic_irq),
        .apic_irq(apic_irq), .route_ok(route_ok)
    );
endmodule

// File: rtl/pirq_router_chk.sv
// Property checker for the interrupt line router, bound to the top.
module pirq_router_chk
    import pirq_router_pkg::*;
#(
    parameter int NSLOT      = 8,
    parameter int FIXED_SLOT = 6,
    parameter int AW         = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [7:0]       wr_data,
    input logic [AW-1:0]    rd_addr,
    input logic [7:0]       rd_data,
    input logic             sci_in,
    input logic [15:0]      pic_irq,
    input logic [7:0]       apic_irq,
    input logic [7:0]       link_lvl,
    input logic [2:0]       sci_code
);
    // R3: advanced pins without an SCI option follow their link only
    a_r3_adv_direct: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (apic_irq[3:0] == $past(link_lvl[3:0])) &&
                         (apic_irq[7:6] == $past(link_lvl[7:6])));

    // R4: SCI with code 0 lands on legacy pin 9
    a_r4_sci_pin9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sci_in) && $past(sci_code) == 3'd0) |-> pic_irq[9]);

    // R5: reserved select codes leave the selection alone
    a_r5_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(SCI_ADDR) &&
         (wr_data[2:0] == 3'd3 || wr_data[2:0] >= 3'd6)) |=> $stable(sci_code));

    // R9: the fixed slot's mapping bytes read as zero
    a_r9_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == AW'(MAP_BASE + 2 * FIXED_SLOT) ||
         rd_addr == AW'(MAP_BASE + 2 * FIXED_SLOT + 1)) |-> rd_data == 8'h00);

    // R11: outputs are quiet after a reset cycle
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pic_irq == 16'h0 && apic_irq == 8'h0));
endmodule

bind pirq_router pirq_router_chk #(.NSLOT(NSLOT), .FIXED_SLOT(FIXED_SLOT), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sci_in(sci_in), .pic_irq(pic_irq), .apic_irq(apic_irq),
    .link_lvl(link_lvl), .sci_code(sci_code)
);

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;
    localparam int NSLOT = 8;
    localparam int FIXED = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic [4*NSLOT-1:0] intx_in = '0;
    logic sci_in = 1'b0;
    logic [15:0] pic_irq;
    logic [7:0] apic_irq, route_ok;

    int n_chk = 0, n_bad = 0;

    logic [7:0] m_route [8];
    logic [2:0] m_sci;
    logic [2:0] m_map [NSLOT][4];

    always #5 clk = ~clk;

    pirq_router #(.NSLOT(NSLOT), .FIXED_SLOT(FIXED), .AW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .intx_in(intx_in), .sci_in(sci_in), .pic_irq(pic_irq),
        .apic_irq(apic_irq), .route_ok(route_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int n = 0; n < 8; n++) m_route[n] = 8'h80;
        m_sci = 3'd0;
        for (int s = 0; s < NSLOT; s++)
            for (int i = 0; i < 4; i++)
                m_map[s][i] = (s == FIXED) ? 3'(4 + i) : 3'(((s + i) % 4) + 4);
    endtask

    function automatic logic code_ok(input logic [2:0] c);
        return c == 0 || c == 1 || c == 2 || c == 4 || c == 5;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a < 8) m_route[a[2:0]] = d & 8'h9F;
        else if (a == 8) begin if (code_ok(d[2:0])) m_sci = d[2:0]; end
        else if (a >= 16 && a < 16 + 2 * NSLOT) begin
            int s = (a - 16) / 2;
            int h = (a - 16) % 2;
            if (s != FIXED) begin
                m_map[s][2*h]   = d[2:0];
                m_map[s][2*h+1] = d[6:4];
            end
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a < 8) return m_route[a[2:0]];
        if (a == 8) return {5'b0, m_sci};
        if (a >= 16 && a < 16 + 2 * NSLOT) begin
            int s = (a - 16) / 2;
            int h = (a - 16) % 2;
            if (s == FIXED) return 8'h00;
            return {1'b0, m_map[s][2*h+1], 1'b0, m_map[s][2*h]};
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_ok();
        logic [7:0] r;
        for (int n = 0; n < 8; n++) r[n] = !m_route[n][7] && !m_route[n][4];
        return r;
    endfunction

    // {apic, pic} expected from the current model and input levels
    function automatic logic [23:0] exp_pins(input logic [4*NSLOT-1:0] v, input logic sci);
        logic [7:0] lk = '0;
        logic [15:0] pic = '0;
        logic [7:0] adv;
        logic [7:0] ok = exp_ok();
        int pin;
        for (int s = 0; s < NSLOT; s++)
            for (int i = 0; i < 4; i++)
                if (v[4*s+i]) lk[m_map[s][i]] = 1'b1;
        adv = lk;
        for (int n = 0; n < 8; n++)
            if (ok[n] && lk[n]) pic[m_route[n][3:0]] = 1'b1;
        case (m_sci)
            3'd1: pin = 10; 3'd2: pin = 11; 3'd4: pin = 20; 3'd5: pin = 21;
            default: pin = 9;
        endcase
        if (sci) begin
            if (pin >= 16) adv[pin-16] = 1'b1; else pic[pin] = 1'b1;
        end
        return {adv, pic};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        rd_addr = a; #1;
        chk(req, {24'h0, rd_data}, {24'h0, exp_rd(a)});
    endtask

    task automatic pins_chk(input string req);
        chk(req, {8'h0, apic_irq, pic_irq}, {8'h0, exp_pins(intx_in, sci_in)});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset outputs", {8'h0, apic_irq, pic_irq}, 32'h0);
        rst_n = 1'b1;
        // R1, R4, R8, R12 reset register values
        rd_chk("R1 route reset", 8'h03);
        rd_chk("R4 sci reset", 8'h08);
        rd_chk("R8 default map", 8'h10);
        rd_chk("R8 default map hi", 8'h13);
        rd_chk("R12 unmapped", 8'h09);
        chk("R10 ok at reset", {24'h0, route_ok}, 32'h0);

        // R8: slot 1 INTA -> link 5 -> advanced bit 5
        @(negedge clk); intx_in = '0; intx_in[4] = 1'b1;
        @(negedge clk);
        chk("R8 slot1 INTA to link5", {24'h0, apic_irq}, 32'h20);
        pins_chk("R3 adv only");

        // R2: enable link 5 onto legacy pin 7
        wr(8'h05, 8'h07);
        @(negedge clk);
        chk("R2 legacy pin 7", {16'h0, pic_irq}, 32'h0080);

        // R10: enabled route with pin 18 drives no legacy pin
        wr(8'h05, 8'h12);
        chk("R10 status", {24'h0, route_ok}, 32'h0);
        @(negedge clk);
        chk("R10 no legacy pin", {16'h0, pic_irq}, 32'h0);
        chk("R3 adv ignores route", {24'h0, apic_irq}, 32'h20);

        // R6: SCI move while asserted; same-update swap
        intx_in = '0; sci_in = 1'b1;
        wr(8'h05, 8'h80);
        @(negedge clk);
        chk("R4 sci on pin 9", {8'h0, apic_irq, pic_irq}, 32'h0200);
        @(negedge clk); wr_en = 1'b1; wr_addr = 8'h08; wr_data = 8'h04;
        @(negedge clk); wr_en = 1'b0; model_write(8'h08, 8'h04);
        chk("R6 old pin until update", {8'h0, apic_irq, pic_irq}, 32'h0200);
        @(negedge clk);
        chk("R6 swap to pin 20", {8'h0, apic_irq, pic_irq}, 32'h10_0000);

        // R5: reserved code ignored
        wr(8'h08, 8'h07);
        rd_chk("R5 readback kept", 8'h08);
        @(negedge clk);
        chk("R5 pin kept", {8'h0, apic_irq, pic_irq}, 32'h10_0000);
        sci_in = 1'b0;

        // R9: fixed slot ignores writes, INTB -> link 5
        wr(8'h10 + 8'(2 * FIXED), 8'h77);
        rd_chk("R9 fixed reads zero", 8'h10 + 8'(2 * FIXED));
        intx_in = '0; intx_in[4*FIXED+1] = 1'b1;
        @(negedge clk);
        chk("R9 fixed INTB to link5", {24'h0, apic_irq}, 32'h20);

        // R7: remap slot 2 INTD onto link 0
        wr(8'h15, 8'h01);
        rd_chk("R7 map readback", 8'h15);
        intx_in = '0; intx_in[4*2+3] = 1'b1;
        @(negedge clk);
        chk("R7 INTD to link0", {24'h0, apic_irq}, 32'h01);

        // Random phase: R1 R2 R3 R4 R5 R7 R10 R11 R12
        for (int it = 0; it < 300; it++) begin
            for (int k = 0; k < 3; k++) begin
                int kind = $urandom % 4;
                logic [7:0] a;
                if (kind == 0) a = 8'($urandom % 8);
                else if (kind == 1) a = 8'h08;
                else if (kind == 2) a = 8'(16 + $urandom % (2 * NSLOT));
                else a = 8'($urandom % 40);
                wr(a, 8'($urandom));
            end
            for (int b = 0; b < 4 * NSLOT; b++) intx_in[b] = ($urandom % 8) == 0;
            sci_in = $urandom % 2;
            chk("R10 random status", {24'h0, route_ok}, {24'h0, exp_ok()});
            @(negedge clk);
            pins_chk("R2 R3 R4 random pins");
            rd_chk("R1 R7 R12 random read", 8'($urandom % 40));
        end

        // R11: reset in mid-run clears outputs
        @(negedge clk); intx_in = '1; sci_in = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset clears", {8'h0, apic_irq, pic_irq}, 32'h0);
        rst_n = 1'b1;

        summary();
        $finish;
    end
endmodule